// File: doc/BRIEF.md
# ADC Multi-Mode Channel Sequencer

This block chooses the analog input channel that a multi-channel converter samples each time a conversion-start pulse arrives. A host writes control words over a synchronous parallel port. Each word carries a two-bit mode code, a channel address and a few configuration bits that the block passes through unchanged. In one mode the next write goes to a shadow mask, where each set bit enrolls one channel.

Four behaviours come from the mode code:
- A fixed single channel.
- A programmable rotation through the channels enabled in the mask, lowest to highest, then wrapping.
- A consecutive rotation from channel 0 up to the addressed channel.
- A "keep" code that updates the configuration bits and leaves a running rotation and its position alone.

The channel output and the sequence-active flag are both registered. A write that arrives in the same cycle as a pulse is applied first.

Top module: `adc_chan_sequencer`

## Requirements
- R1: After reset `chan` is 0, `seq_active` is 0 and `cfg` is 0. The mode is single-channel, the shadow mask is cleared and no shadow write is pending.
- R2: A control word holds the channel address in bits [2:0], the mode code {seq,shdw} in bits [4:3] and the configuration field in bits [8:5]. In mode code 00 every conversion uses the address from the last write, and `seq_active` is 0.
- R3: A write with code 01 makes the next write a shadow write. That write's bits [7:0] become the channel mask, bit n enrolling channel n. A shadow write does not change `cfg`. After it, `seq_active` is 1.
- R4: In mask mode, the first conversion after the shadow write uses the lowest enrolled channel. Each later conversion uses the next higher enrolled channel, and after the highest one the rotation wraps to the lowest.
- R5: A shadow mask of all zeros makes every mask-mode conversion use channel 0.
- R6: A write with code 11 starts consecutive mode, and `seq_active` becomes 1. The first conversion uses channel 0, then channel 1 and so on up to the address in bits [2:0], after which the rotation returns to 0.
- R7: A write with code 10 loads `cfg`. It leaves the mode, the rotation position, the stored address, the mask, `chan` and `seq_active` unchanged.
- R8: A write with code 00 or 01 ends any running sequence: `seq_active` reads 0 in the cycle after that write. While a shadow write is pending, conversions use the address given with the 01 write.
- R9: `chan` changes only on the clock edge at which `cnv_start` is high, and the new value is visible from the following cycle.
- R10: If a write and a conversion pulse arrive in the same cycle, the write takes effect first and that conversion follows the new mode.
- R11: `cfg` shows the configuration field of the most recent control write that was not a shadow write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 9 | Control word, or shadow mask when a shadow write is pending |
| cnv_start | input | 1 | Conversion-start pulse |
| chan | output | 3 | Channel used by the latest conversion |
| seq_active | output | 1 | High while a mask or consecutive rotation is in force |
| cfg | output | 4 | Pass-through configuration bits |

## Verification
The assertions assume that `wr_en` and `cnv_start` are clean single-cycle levels, sampled only at the rising edge. They assume `wr_data` is fully defined whenever `wr_en` is high. They also rely on the mask register changing only through a shadow write, so mask-mode checks that look one cycle ahead are made only in cycles without a write. The stimulus drives every input from the falling edge with defined values. It mixes a fixed-seed random stream of writes, with every mode code and arbitrary addresses, masks and configuration bits, with directed runs that cover wrap points, an empty mask and collisions between a write and a pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_MASK   = 2'd1,
    MODE_CONSEC = 2'd2
  } seq_mode_e;

  // Mode code carried in the control word as {seq, shdw}
  localparam logic [1:0] CODE_SINGLE = 2'b00;
  localparam logic [1:0] CODE_SHADOW = 2'b01;
  localparam logic [1:0] CODE_KEEP   = 2'b10;
  localparam logic [1:0] CODE_CONSEC = 2'b11;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3,
  parameter int CFG_W  = 4,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cnv_start,
  output seq_mode_e         eff_mode,
  output logic [CH_W-1:0]   eff_addr,
  output logic [NUM_CH-1:0] eff_mask,
  output logic              eff_restart,
  output logic [NUM_CH-1:0] mask_q,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              seq_active_q
);

  localparam int CODE_LSB = CH_W;
  localparam int CFG_LSB  = CH_W + 2;

  seq_mode_e         mode_q;
  logic [CH_W-1:0]   addr_q;
  logic              pending_q;
  logic              restart_q;

  logic [CH_W-1:0]   f_addr;
  logic [1:0]        f_code;
  logic [CFG_W-1:0]  f_cfg;
  logic [NUM_CH-1:0] f_mask;

  logic              n_pending;
  logic [CFG_W-1:0]  n_cfg;
  logic              restart_set;

  assign f_addr = wr_data[CH_W-1:0];
  assign f_code = wr_data[CODE_LSB+1:CODE_LSB];
  assign f_cfg  = wr_data[CFG_LSB+CFG_W-1:CFG_LSB];
  assign f_mask = wr_data[NUM_CH-1:0];

  // Write decode; the outcome is visible combinationally so a same-cycle
  // conversion follows the new settings.
  always_comb begin
    eff_mode    = mode_q;
    eff_addr    = addr_q;
    eff_mask    = mask_q;
    n_pending   = pending_q;
    n_cfg       = cfg_q;
    restart_set = 1'b0;
    if (wr_en) begin
      if (pending_q) begin
        eff_mask    = f_mask;
        eff_mode    = MODE_MASK;
        n_pending   = 1'b0;
        restart_set = 1'b1;
      end else begin
        unique case (f_code)
          CODE_SINGLE: begin
            eff_mode = MODE_SINGLE;
            eff_addr = f_addr;
            n_cfg    = f_cfg;
          end
          CODE_SHADOW: begin
            eff_mode  = MODE_SINGLE;
            eff_addr  = f_addr;
            n_cfg     = f_cfg;
            n_pending = 1'b1;
          end
          CODE_KEEP: begin
            n_cfg = f_cfg;
          end
          default: begin
            eff_mode    = MODE_CONSEC;
            eff_addr    = f_addr;
            n_cfg       = f_cfg;
            restart_set = 1'b1;
          end
        endcase
      end
    end
  end

  assign eff_restart = restart_q | restart_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MODE_SINGLE;
      addr_q       <= '0;
      mask_q       <= '0;
      pending_q    <= 1'b0;
      restart_q    <= 1'b0;
      cfg_q        <= '0;
      seq_active_q <= 1'b0;
    end else begin
      mode_q       <= eff_mode;
      addr_q       <= eff_addr;
      mask_q       <= eff_mask;
      pending_q    <= n_pending;
      restart_q    <= cnv_start ? 1'b0 : eff_restart;
      cfg_q        <= n_cfg;
      seq_active_q <= (eff_mode != MODE_SINGLE);
    end
  end

  assert_keep_mode_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !pending_q && f_code == CODE_KEEP) |=> $stable(seq_active_q))
    else $error("keep write changed sequence state");

  assert_seq_end_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !pending_q && !f_code[1]) |=> !seq_active_q)
    else $error("sequence not ended");

  assert_shadow_cfg_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pending_q) |=> ($stable(cfg_q) && seq_active_q))
    else $error("shadow write disturbed cfg or did not start");

endmodule

// File: rtl/adc_seq_scan.sv
module adc_seq_scan #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   cur,
  output logic [CH_W-1:0]   lowest,
  output logic [CH_W-1:0]   next_up
);

  logic [NUM_CH-1:0] above;

  genvar j;
  generate
    for (j = 0; j < NUM_CH; j++) begin : g_above
      assign above[j] = mask[j] && (CH_W'(j) > cur);
    end
  endgenerate

  // Priority encoders: the lowest set bit wins; an empty vector gives 0.
  always_comb begin
    lowest = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (mask[k]) lowest = CH_W'(k);
    end
  end

  always_comb begin
    next_up = lowest;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (above[k]) next_up = CH_W'(k);
    end
  end

endmodule

// File: rtl/adc_seq_ptr.sv
module adc_seq_ptr
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cnv_start,
  input  seq_mode_e       eff_mode,
  input  logic [CH_W-1:0] eff_addr,
  input  logic            eff_restart,
  input  logic [CH_W-1:0] scan_lowest,
  input  logic [CH_W-1:0] scan_next,
  output logic [CH_W-1:0] chan_q
);

  logic [CH_W-1:0] nxt;

  always_comb begin
    unique case (eff_mode)
      MODE_MASK:   nxt = eff_restart ? scan_lowest : scan_next;
      MODE_CONSEC: nxt = (eff_restart || chan_q >= eff_addr) ? '0 : chan_q + 1'b1;
      default:     nxt = eff_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            chan_q <= '0;
    else if (cnv_start) chan_q <= nxt;
  end

  assert_chan_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cnv_start |=> $stable(chan_q))
    else $error("channel moved without a pulse");

  assert_consec_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (cnv_start && eff_mode == MODE_CONSEC) |=> (chan_q <= $past(eff_addr)))
    else $error("consecutive channel beyond limit");

  assert_consec_start_R10: assert property (@(posedge clk) disable iff (rst)
    (cnv_start && eff_mode == MODE_CONSEC && eff_restart) |=> (chan_q == '0))
    else $error("consecutive rotation did not start at 0");

endmodule

// File: rtl/adc_chan_sequencer.sv
module adc_chan_sequencer
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CFG_W  = 4,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int DATA_W = (NUM_CH > CH_W + 2 + CFG_W) ? NUM_CH : CH_W + 2 + CFG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cnv_start,
  output logic [CH_W-1:0]   chan,
  output logic              seq_active,
  output logic [CFG_W-1:0]  cfg
);

  seq_mode_e         eff_mode;
  logic [CH_W-1:0]   eff_addr;
  logic [NUM_CH-1:0] eff_mask;
  logic              eff_restart;
  logic [NUM_CH-1:0] mask_q;
  logic [CH_W-1:0]   scan_lowest;
  logic [CH_W-1:0]   scan_next;

  adc_seq_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .CFG_W(CFG_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cnv_start(cnv_start), .eff_mode(eff_mode), .eff_addr(eff_addr),
    .eff_mask(eff_mask), .eff_restart(eff_restart), .mask_q(mask_q),
    .cfg_q(cfg), .seq_active_q(seq_active)
  );

  adc_seq_scan #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_scan (
    .mask(eff_mask), .cur(chan), .lowest(scan_lowest), .next_up(scan_next)
  );

  adc_seq_ptr #(.CH_W(CH_W)) u_ptr (
    .clk(clk), .rst(rst), .cnv_start(cnv_start), .eff_mode(eff_mode),
    .eff_addr(eff_addr), .eff_restart(eff_restart),
    .scan_lowest(scan_lowest), .scan_next(scan_next), .chan_q(chan)
  );

  assert_mask_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (cnv_start && !wr_en && eff_mode == MODE_MASK && eff_mask != '0) |=> mask_q[chan])
    else $error("mask-mode channel not enrolled");

  assert_empty_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (cnv_start && eff_mode == MODE_MASK && eff_mask == '0) |=> (chan == '0))
    else $error("empty mask gave nonzero channel");

endmodule

// File: tb/test_adc_chan_sequencer.sv
`timescale 1ns/1ps
module test_adc_chan_sequencer;

  localparam int NUM_CH = 8;
  localparam int CH_W   = 3;
  localparam int CFG_W  = 4;
  localparam int DATA_W = 9;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              cnv_start = 1'b0;
  logic [CH_W-1:0]   chan;
  logic              seq_active;
  logic [CFG_W-1:0]  cfg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  adc_chan_sequencer i_adc_chan_sequencer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cnv_start(cnv_start), .chan(chan), .seq_active(seq_active), .cfg(cfg)
  );

  // Reference model built from the requirements (0 single, 1 mask, 2 consec)
  int              m_mode;
  logic [CH_W-1:0] m_addr;
  logic [7:0]      m_mask;
  bit              m_pend, m_restart, m_act;
  logic [CH_W-1:0] m_chan;
  logic [CFG_W-1:0] m_cfg;

  function automatic logic [DATA_W-1:0] word(input logic [1:0] code,
      input logic [2:0] addr, input logic [3:0] c);
    return {c, code, addr};
  endfunction

  function automatic logic [2:0] low_of(input logic [7:0] m);
    for (int k = 0; k < 8; k++) if (m[k]) return 3'(k);
    return 3'd0;
  endfunction

  function automatic logic [2:0] next_of(input logic [7:0] m, input logic [2:0] c);
    for (int k = int'(c) + 1; k < 8; k++) if (m[k]) return 3'(k);
    return low_of(m);
  endfunction

  task automatic model_reset();
    m_mode = 0; m_addr = '0; m_mask = '0; m_pend = 0; m_restart = 0;
    m_act = 0; m_chan = '0; m_cfg = '0;
  endtask

  task automatic model_step(input bit w, input logic [DATA_W-1:0] d, input bit c);
    bit rs = 0;
    if (w) begin
      if (m_pend) begin
        m_mask = d[7:0]; m_mode = 1; m_pend = 0; rs = 1;
      end else begin
        case (d[4:3])
          2'b00: begin m_mode = 0; m_addr = d[2:0]; m_cfg = d[8:5]; end
          2'b01: begin m_mode = 0; m_addr = d[2:0]; m_cfg = d[8:5]; m_pend = 1; end
          2'b10: m_cfg = d[8:5];
          default: begin m_mode = 2; m_addr = d[2:0]; m_cfg = d[8:5]; rs = 1; end
        endcase
      end
    end
    if (rs) m_restart = 1;
    if (c) begin
      case (m_mode)
        1: m_chan = m_restart ? low_of(m_mask) : next_of(m_mask, m_chan);
        2: m_chan = (m_restart || m_chan >= m_addr) ? 3'd0 : m_chan + 3'd1;
        default: m_chan = m_addr;
      endcase
      m_restart = 0;
    end
    m_act = (m_mode != 0);
  endtask

  task automatic check_model(input string tag);
    checks++;
    if (chan !== m_chan || seq_active !== m_act || cfg !== m_cfg) begin
      fails++;
      $display("FAIL %s: chan=%0d act=%0b cfg=%0h expected chan=%0d act=%0b cfg=%0h",
               tag, chan, seq_active, cfg, m_chan, m_act, m_cfg);
    end
  endtask

  task automatic check_chan(input string tag, input logic [2:0] exp);
    checks++;
    if (chan !== exp) begin
      fails++;
      $display("FAIL %s: chan=%0d expected %0d", tag, chan, exp);
    end
  endtask

  // Called at a falling edge; drives, lets one rising edge pass, checks at the next fall
  task automatic cyc(input bit w, input logic [DATA_W-1:0] d, input bit c, input string tag);
    wr_en = w; wr_data = d; cnv_start = c;
    @(posedge clk);
    model_step(w, d, c);
    @(negedge clk);
    wr_en = 0; cnv_start = 0;
    check_model(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    check_model("R1 reset state");
    cyc(0, '0, 1, "R1 pulse after reset");
    check_chan("R1 channel 0", 3'd0);

    // R2 single mode
    cyc(1, word(2'b00, 3'd5, 4'h3), 0, "R2 single write");
    cyc(0, '0, 1, "R2 single conversion");
    check_chan("R2 address 5", 3'd5);
    cyc(0, '0, 1, "R2 repeat");

    // R3/R4 shadow mask 10100100 -> 2,5,7,2
    cyc(1, word(2'b01, 3'd6, 4'h9), 0, "R3 shadow request");
    cyc(0, '0, 1, "R8 pending uses address");
    check_chan("R8 pending address 6", 3'd6);
    cyc(1, 9'h0A4, 0, "R3 shadow load");
    cyc(0, '0, 1, "R4 first lowest");
    check_chan("R4 lowest", 3'd2);
    cyc(0, '0, 1, "R4 next");
    check_chan("R4 next", 3'd5);
    cyc(0, '0, 0, "R9 no pulse hold");
    cyc(0, '0, 1, "R4 highest");
    check_chan("R4 highest", 3'd7);
    // R7 keep write in the middle of the rotation
    cyc(1, word(2'b10, 3'd1, 4'hC), 0, "R7 keep write");
    cyc(0, '0, 1, "R4 wrap");
    check_chan("R4 wrap to lowest", 3'd2);
    cyc(1, word(2'b10, 3'd0, 4'h5), 1, "R7 keep with pulse");
    check_chan("R7 position kept", 3'd5);

    // R5 empty mask
    cyc(1, word(2'b01, 3'd3, 4'h1), 0, "R8 shadow request ends");
    cyc(1, 9'h000, 0, "R5 empty load");
    cyc(0, '0, 1, "R5 empty");
    check_chan("R5 zero mask", 3'd0);
    cyc(0, '0, 1, "R5 empty again");

    // R6 consecutive to 3 with R10 collision
    cyc(1, word(2'b11, 3'd3, 4'h7), 1, "R10 write+pulse consec");
    check_chan("R10 first is 0", 3'd0);
    for (int i = 1; i <= 4; i++) cyc(0, '0, 1, "R6 consecutive step");
    check_chan("R6 wrapped", 3'd0);
    cyc(1, word(2'b00, 3'd4, 4'h2), 1, "R10 write+pulse single");
    check_chan("R10 single 4", 3'd4);
    cyc(1, word(2'b11, 3'd0, 4'hA), 0, "R6 limit 0");
    cyc(0, '0, 1, "R6 limit 0 step");
    cyc(0, '0, 1, "R6 limit 0 again");
    check_chan("R6 only channel 0", 3'd0);
    cyc(1, word(2'b00, 3'd1, 4'hF), 0, "R8 end consec");
    cyc(1, word(2'b01, 3'd0, 4'h4), 0, "R3 request");
    cyc(1, 9'h180, 1, "R10 shadow+pulse");
    check_chan("R10 lowest of new mask", 3'd7);
    cyc(1, word(2'b10, 3'd2, 4'h6), 0, "R11 cfg update");

    // Random stream
    for (int i = 0; i < 4000; i++) begin
      bit w = ($urandom % 4) == 0;
      bit c = ($urandom % 2) == 0;
      logic [DATA_W-1:0] d = DATA_W'($urandom);
      cyc(w, d, c, "R9 R11 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule